// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This block is a purely combinational 32-bit helper that sits beside the main adder of a small soft-processor ALU. It computes one of five results from two operands, `opa` and `opb`, and a carry-in. The result is picked by a 3-bit operation code.

The five operations are:
- Two compare flavours that return the difference `opb - opa`. When the operand signs differ, the top bit is rewritten so that it gives the true signed or unsigned ordering.
- A byte-equality search that reports the first matching byte lane, scanning from the most significant lane.
- The carry-out of `opa + opb + cin`.
- A leading-zero count of `opa`.

Nothing inside the block is stored. The outputs follow the inputs within the same cycle, and the surrounding pipeline registers them.

Top module: `intcmp_unit`

## Requirements
- R1: With `op_sel` = 0 (signed compare) or 1 (unsigned compare) and equal operand sign bits (bit 31), `result` equals `opb - opa` modulo 2^32.
- R2: With `op_sel` = 0 and differing sign bits, `result[30:0]` equals the low 31 bits of `opb - opa`, and `result[31]` equals `opb[31]`. In every signed case, `result[31]` is 1 exactly when `opb < opa` as signed values.
- R3: With `op_sel` = 1 and differing sign bits, `result[31]` equals `opa[31]` and the low 31 bits are the difference. In every unsigned case, `result[31]` is 1 exactly when `opb < opa` as unsigned values.
- R4: With `op_sel` = 2, byte lanes are compared from bits 31:24 (lane value 1) down to bits 7:0 (lane value 4). `result` is the value of the first equal lane, zero-extended, so a higher lane wins over any lower one.
- R5: With `op_sel` = 2 and no equal lane, `result` is 0.
- R6: With `op_sel` = 3, `cout` is the carry out of bit 31 of `opa + opb + cin`. `result` equals `cout` zero-extended, and an all-ones `opb` with `cin` = 1 always gives a carry.
- R7: With `op_sel` = 4, `result` is the number of zero bits of `opa` above its highest set bit, and it is 32 when `opa` is zero.
- R8: Codes 5, 6 and 7 give `result` = 0.
- R9: `cout` is 0 for every code other than 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand (subtrahend for compares, source for leading-zero count) |
| opb | input | 32 | Second operand |
| cin | input | 1 | Carry-in for the carry operation |
| op_sel | input | 3 | Operation code: 0 signed compare, 1 unsigned compare, 2 byte match, 3 carry, 4 leading zeros |
| result | output | 32 | Selected result |
| cout | output | 1 | Carry-out, valid only for code 3 |

## Verification
The bench aims at the sign boundary, for example 0x80000000 against 0x7FFFFFFF, in both directions. A compare that forgot the override, or took the top bit from the wrong operand, would give the wrong ordering bit there while still passing for same-sign operands. For byte match it drives operands that are equal in several lanes at once, where a design with reversed priority returns 4 instead of 1. It also drives operands that differ in every lane, where an off-by-one index shows. Carry is driven at an all-ones `opb` with `cin` set and at sums that land just below and just above 2^32, and leading zeros at zero, one and the top bit alone.

// File: rtl/intcmp_pkg.sv
package intcmp_pkg;

    localparam int unsigned LANE_BITS = 8;

    typedef enum logic [2:0] {
        OP_SCMP   = 3'd0,
        OP_UCMP   = 3'd1,
        OP_BMATCH = 3'd2,
        OP_CARRY  = 3'd3,
        OP_CLZ    = 3'd4
    } icu_op_e;

    typedef struct packed {
        logic signs_differ;
        logic a_top;
        logic b_top;
    } sign_info_t;

endpackage

// File: rtl/intcmp_diff.sv
module intcmp_diff #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s_res,
    output logic [W-1:0] u_res
);
    import intcmp_pkg::*;

    logic [W-1:0] diff;
    sign_info_t   si;

    always_comb begin
        diff            = b + ~a + {{(W-1){1'b0}}, 1'b1};
        si.a_top        = a[W-1];
        si.b_top        = b[W-1];
        si.signs_differ = si.a_top ^ si.b_top;
        s_res = si.signs_differ ? {si.b_top, diff[W-2:0]} : diff;
        u_res = si.signs_differ ? {si.a_top, diff[W-2:0]} : diff;
    end
endmodule

// File: rtl/intcmp_lane.sv
module intcmp_lane #(
    parameter int unsigned W  = 32,
    parameter int unsigned NL = W / intcmp_pkg::LANE_BITS,
    parameter int unsigned IW = $clog2(NL + 1)
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [IW-1:0] idx
);
    localparam int unsigned LB = intcmp_pkg::LANE_BITS;

    logic [NL-1:0] eq;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign eq[g] = (a[g*LB +: LB] == b[g*LB +: LB]);
    end

    // Scan upward so the most significant equal lane is written last.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NL; i++) begin
            if (eq[i]) idx = IW'(NL - i);
        end
    end
endmodule

// File: rtl/intcmp_carry.sv
module intcmp_carry #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = cin;
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign c[g+1] = (a[g] & b[g]) | ((a[g] ^ b[g]) & c[g]);
    end
    assign co = c[W];
endmodule

// File: rtl/intcmp_clz.sv
module intcmp_clz #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  a,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/intcmp_unit.sv
module intcmp_unit #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         cout
);
    import intcmp_pkg::*;

    localparam int unsigned NL = W / LANE_BITS;
    localparam int unsigned IW = $clog2(NL + 1);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  s_res, u_res;
    logic [IW-1:0] lane_idx;
    logic [CW-1:0] lz_cnt;
    logic          carry;
    icu_op_e       op;

    intcmp_diff  #(.W(W)) u_diff  (.a(opa), .b(opb), .s_res(s_res), .u_res(u_res));
    intcmp_lane  #(.W(W), .NL(NL), .IW(IW)) u_lane (.a(opa), .b(opb), .idx(lane_idx));
    intcmp_carry #(.W(W)) u_carry (.a(opa), .b(opb), .cin(cin), .co(carry));
    intcmp_clz   #(.W(W), .CW(CW)) u_clz (.a(opa), .cnt(lz_cnt));

    always_comb begin
        op     = icu_op_e'(op_sel);
        result = '0;
        cout   = 1'b0;
        case (op)
            OP_SCMP:   result = s_res;
            OP_UCMP:   result = u_res;
            OP_BMATCH: result = W'(lane_idx);
            OP_CARRY: begin
                result = W'(carry);
                cout   = carry;
            end
            OP_CLZ:    result = W'(lz_cnt);
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/intcmp_unit_chk.sv
module intcmp_unit_chk #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         cin,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         cout
);
    always_comb begin
        if (!$isunknown({opa, opb, cin, op_sel})) begin
            // R1
            same_sign_diff_chk: assert (!(op_sel <= 3'd1 && opa[W-1] == opb[W-1])
                                        || result == opb - opa)
                else $error("same-sign compare result mismatch");
            // R4
            lane_range_chk: assert (op_sel != 3'd2 || result <= W'(W / 8))
                else $error("byte match index out of range");
            // R6
            carry_echo_chk: assert (op_sel != 3'd3 || result == W'(cout))
                else $error("carry result does not mirror cout");
            // R7
            clz_range_chk: assert (op_sel != 3'd4 || result <= W'(W))
                else $error("leading zero count out of range");
            // R8
            unused_code_chk: assert (op_sel <= 3'd4 || result == '0)
                else $error("unused code gave nonzero result");
            // R9
            cout_idle_chk: assert (op_sel == 3'd3 || !cout)
                else $error("cout set outside carry operation");
        end
    end
endmodule

bind intcmp_unit intcmp_unit_chk #(.W(W)) u_chk (
    .opa(opa), .opb(opb), .cin(cin), .op_sel(op_sel),
    .result(result), .cout(cout)
);

// File: tb/intcmp_unit_tb.sv
module intcmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0, opb = '0;
    logic        cin = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic        cout;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    intcmp_unit u_dut (.opa(opa), .opb(opb), .cin(cin), .op_sel(op_sel),
                       .result(result), .cout(cout));

    function automatic string tag_of(input logic [2:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
        case (op)
            3'd0: return (a[31] == b[31]) ? "R1" : "R2";
            3'd1: return (a[31] == b[31]) ? "R1" : "R3";
            3'd2: return "R4/R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic c);
        logic [31:0] d;
        longint unsigned s;
        d = b - a;
        case (op)
            3'd0: return {($signed(b) < $signed(a)), d[30:0]};
            3'd1: return {(b < a), d[30:0]};
            3'd2: begin
                for (int k = 0; k < 4; k++)
                    if (a[31-8*k -: 8] == b[31-8*k -: 8]) return 32'(k + 1);
                return 32'd0;
            end
            3'd3: begin
                s = longint'(a) + longint'(b) + longint'(c);
                return 32'(s >> 32);
            end
            3'd4: begin
                for (int k = 31; k >= 0; k--)
                    if (a[k]) return 32'(31 - k);
                return 32'd32;
            end
            default: return 32'd0;
        endcase
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input logic [2:0] op);
        logic [31:0] er;
        logic        ec;
        @(posedge clk);
        #1;
        opa = a; opb = b; cin = c; op_sel = op;
        @(negedge clk);
        er = ref_res(op, a, b, c);
        ec = (op == 3'd3) ? er[0] : 1'b0;
        n_chk++;
        if (result !== er) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%0d result actual=%h expected=%h",
                     tag_of(op, a, b), op, a, b, c, result, er);
        end
        n_chk++;
        if (cout !== ec) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%0d cout actual=%0d expected=%0d",
                     (op == 3'd3) ? "R6" : "R9", op, a, b, c, cout, ec);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle/reset state: zero inputs, signed compare gives 0, no carry
        run(32'h0, 32'h0, 1'b0, 3'd0);
        for (int op = 0; op < 8; op++) begin
            // R2 R3 sign boundary, R1 equal operands
            run(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 3'(op));
            run(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 3'(op));
            run(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 3'(op));
            run(32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 3'(op));
            run(32'h1234_5678, 32'h1234_5678, 1'b0, 3'(op));
            run(32'h0000_0000, 32'h0000_0000, 1'b1, 3'(op));
        end
        // R4 priority, R5 no match
        run(32'hAA00_BB00, 32'hAA11_BB22, 1'b0, 3'd2);
        run(32'h11AA_BBCC, 32'h22AA_BBCC, 1'b0, 3'd2);
        run(32'h1122_33CC, 32'h4455_66CC, 1'b0, 3'd2);
        run(32'h0102_0304, 32'h1020_3040, 1'b0, 3'd2);
        // R6 carry edges
        run(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 3'd3);
        run(32'h0000_0001, 32'hFFFF_FFFE, 1'b0, 3'd3);
        run(32'h0000_0001, 32'hFFFF_FFFE, 1'b1, 3'd3);
        run(32'h8000_0000, 32'h8000_0000, 1'b0, 3'd3);
        // R7 leading zeros
        run(32'h0000_0001, 32'h0, 1'b0, 3'd4);
        run(32'h8000_0000, 32'h0, 1'b0, 3'd4);
        run(32'h0001_F000, 32'h0, 1'b0, 3'd4);
        // random sweep, all codes (R8 R9 included)
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (i % 4 == 0) ? (ra ^ (32'hFF << (8 * (i % 3)))) : $urandom;
            if (i % 7 == 0) ra = ra >> (i % 32);
            run(ra, rb, 1'($urandom), 3'(i % 8));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule